// File: doc/BRIEF.md
# Auxiliary DAC Serial Control Port

This block receives a three-wire, write-only serial stream and turns each 16-bit frame into register updates for three auxiliary converter codes (9, 10 and 8 bits wide) and a digital flag output with a separate drive enable. The external serial clock, serial data and latch lines are treated as asynchronous. They are brought into the core clock domain through a synchronizer, and their edges are detected there. While the latch line is low, each falling edge of the serial clock shifts one data bit into a 16-bit frame register, most significant bit first.

When the latch line rises, the frame is decoded. Three one-hot select bits choose which converter registers take the LSB-aligned data field, and any combination of them may be set. The flag level and the flag drive enable are updated on every latch rise. Each converter register also reports a low-power indication whenever it holds all zeros or all ones. The port operates independently of any other datapath on the chip.

Top module: `aux_dac_port`

## Requirements
- R1: While the synchronized latch line is low, each falling edge of `ser_clk_i` shifts `ser_dat_i` into the frame register at bit 0, moving the earlier bits one place toward bit 15. The first bit sent therefore ends up as bit 15.
- R2: While the latch line is high, serial clock edges leave the frame register unchanged.
- R3: On a rising edge of the latch line, each selected converter register loads the LSB-aligned data field (frame bits 9:0). Frame bit 11 selects converter 1, which takes bits 8:0. Frame bit 12 selects converter 2, which takes bits 9:0. Frame bit 10 selects converter 3, which takes bits 7:0. Several select bits may be set in the same frame.
- R4: A converter register whose select bit is clear in the latched frame keeps its previous code.
- R5: Every latch rise loads frame bit 15 into `flag_o` and frame bit 14 into `flag_oe_o`. Between latch rises, both outputs hold their values.
- R6: Frame bit 13 has no effect on any output.
- R7: `dac_lowpwr_o` bit 0, bit 1 and bit 2 belong to converters 1, 2 and 3 respectively. Each bit is high exactly when that converter's code is all zeros or all ones.
- R8: A frame with fewer or more than 16 serial clocks uses the last 16 bits shifted. With fewer clocks, the upper bits are the low bits of the previous frame.
- R9: While `rst_ni` is low, all codes are zero, `dac_lowpwr_o` is 3'b111, `flag_o` is low and `flag_oe_o` is low.
- R10: A serial input change that is sampled at core clock edge k affects the outputs after edge k+2. For example, a latch rise driven between two edges changes the outputs on the third rising edge after it and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; data shifts on its falling edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_lat_i | input | 1 | Latch line: low while shifting, rising edge commits the frame |
| dac1_code_o | output | DAC1_W (9) | Converter 1 code |
| dac2_code_o | output | DAC2_W (10) | Converter 2 code |
| dac3_code_o | output | DAC3_W (8) | Converter 3 code |
| dac_lowpwr_o | output | 3 | Per-converter low-power indication |
| flag_o | output | 1 | Flag level |
| flag_oe_o | output | 1 | Flag three-state drive enable |

## Verification
Every serial input passes through two synchronizer flops and one edge-history flop. A shift or a commit therefore becomes visible at the outputs three core-clock rising edges after the input edge that caused it. The bench feeds the sampled inputs into a delay queue and evaluates edges on the entries two and three samples old. It compares the outputs on every falling clock edge, so that the comparison sits between updates. Directed checks raise the latch on a falling edge and confirm that the outputs are unchanged after two rising edges and updated after the third. Frame results are then checked against values worked out by hand from the bit positions.

// File: rtl/aux_port_pkg.sv
package aux_port_pkg;
  localparam int FRAME_W   = 16;
  localparam int DATA_W    = 10;
  localparam int NUM_DAC   = 3;
  // control field positions, decoded by the register bank
  localparam int SEL3_BIT  = 10;
  localparam int SEL1_BIT  = 11;
  localparam int SEL2_BIT  = 12;
  localparam int SPARE_BIT = 13;
  localparam int OE_BIT    = 14;
  localparam int FLAG_BIT  = 15;
  // order of the synchronized bundle
  localparam int SY_CLK    = 2;
  localparam int SY_LAT    = 1;
  localparam int SY_DAT    = 0;
endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/aux_shift.sv
module aux_shift
  import aux_port_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               lat_i,
  input  logic               dat_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               shift_en_o,
  output logic               lat_pulse_o
);
  logic               sclk_q, lat_q;
  logic [FRAME_W-1:0] frame_q;

  // idle levels are high, so no edge is seen on release of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      lat_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      lat_q  <= lat_i;
    end
  end

  assign shift_en_o  = sclk_q & ~sclk_i & ~lat_i;
  assign lat_pulse_o = lat_i & ~lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         frame_q <= '0;
    else if (shift_en_o) frame_q <= {frame_q[FRAME_W-2:0], dat_i};
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/aux_dac_reg.sv
module aux_dac_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] code_o,
  output logic         lowpwr_o
);
  logic [W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (load_i) code_q <= data_i;
  end

  assign code_o   = code_q;
  assign lowpwr_o = (code_q == '0) | (code_q == '1);
endmodule

// File: rtl/aux_dac_port.sv
module aux_dac_port
  import aux_port_pkg::*;
#(
  parameter int DAC1_W      = 9,
  parameter int DAC2_W      = 10,
  parameter int DAC3_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ser_clk_i,
  input  logic                ser_dat_i,
  input  logic                ser_lat_i,
  output logic [DAC1_W-1:0]   dac1_code_o,
  output logic [DAC2_W-1:0]   dac2_code_o,
  output logic [DAC3_W-1:0]   dac3_code_o,
  output logic [NUM_DAC-1:0]  dac_lowpwr_o,
  output logic                flag_o,
  output logic                flag_oe_o
);
  localparam int DAC_W   [NUM_DAC] = '{DAC1_W, DAC2_W, DAC3_W};
  localparam int SEL_POS [NUM_DAC] = '{SEL1_BIT, SEL2_BIT, SEL3_BIT};

  logic [2:0]         raw, syn;
  logic               sclk_s, lat_s, dat_s;
  logic [FRAME_W-1:0] frame;
  logic               shift_en, lat_pulse;
  logic [NUM_DAC-1:0] sel;
  logic               flag_q, flag_oe_q;
  logic               unused_spare;

  assign raw[SY_CLK] = ser_clk_i;
  assign raw[SY_LAT] = ser_lat_i;
  assign raw[SY_DAT] = ser_dat_i;

  aux_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign sclk_s = syn[SY_CLK];
  assign lat_s  = syn[SY_LAT];
  assign dat_s  = syn[SY_DAT];

  aux_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_s),
    .lat_i      (lat_s),
    .dat_i      (dat_s),
    .frame_o    (frame),
    .shift_en_o (shift_en),
    .lat_pulse_o(lat_pulse)
  );

  for (genvar g = 0; g < NUM_DAC; g++) begin : gen_dac
    localparam int W = DAC_W[g];
    logic [W-1:0] code_q;
    assign sel[g] = frame[SEL_POS[g]];
    aux_dac_reg #(.W(W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (lat_pulse & sel[g]),
      .data_i  (frame[W-1:0]),
      .code_o  (code_q),
      .lowpwr_o(dac_lowpwr_o[g])
    );
  end

  assign dac1_code_o = gen_dac[0].code_q;
  assign dac2_code_o = gen_dac[1].code_q;
  assign dac3_code_o = gen_dac[2].code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= 1'b0;
      flag_oe_q <= 1'b0;
    end else if (lat_pulse) begin
      flag_q    <= frame[FLAG_BIT];
      flag_oe_q <= frame[OE_BIT];
    end
  end

  assign flag_o       = flag_q;
  assign flag_oe_o    = flag_oe_q;
  assign unused_spare = frame[SPARE_BIT];
endmodule

// File: rtl/aux_dac_port_chk.sv
module aux_dac_port_chk
  import aux_port_pkg::*;
#(
  parameter int DAC1_W = 9,
  parameter int DAC2_W = 10,
  parameter int DAC3_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               shift_en,
  input logic               lat_pulse,
  input logic               lat_s,
  input logic               dat_s,
  input logic [FRAME_W-1:0] frame,
  input logic [DAC1_W-1:0]  dac1_code_o,
  input logic [DAC2_W-1:0]  dac2_code_o,
  input logic [DAC3_W-1:0]  dac3_code_o,
  input logic               flag_o,
  input logic               flag_oe_o
);
  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni) // R1
    shift_en |=> frame == {$past(frame[FRAME_W-2:0]), $past(dat_s)});

  AST_LAT_HIGH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) // R2
    lat_s |=> $stable(frame));

  AST_LOAD_DAC1: assert property (@(posedge clk_i) disable iff (!rst_ni) // R3
    (lat_pulse && frame[SEL1_BIT]) |=> dac1_code_o == $past(frame[DAC1_W-1:0]));

  AST_LOAD_DAC2: assert property (@(posedge clk_i) disable iff (!rst_ni) // R3
    (lat_pulse && frame[SEL2_BIT]) |=> dac2_code_o == $past(frame[DAC2_W-1:0]));

  AST_LOAD_DAC3: assert property (@(posedge clk_i) disable iff (!rst_ni) // R3
    (lat_pulse && frame[SEL3_BIT]) |=> dac3_code_o == $past(frame[DAC3_W-1:0]));

  AST_HOLD_DAC1: assert property (@(posedge clk_i) disable iff (!rst_ni) // R4
    !(lat_pulse && frame[SEL1_BIT]) |=> $stable(dac1_code_o));

  AST_HOLD_DAC2: assert property (@(posedge clk_i) disable iff (!rst_ni) // R4
    !(lat_pulse && frame[SEL2_BIT]) |=> $stable(dac2_code_o));

  AST_HOLD_DAC3: assert property (@(posedge clk_i) disable iff (!rst_ni) // R4
    !(lat_pulse && frame[SEL3_BIT]) |=> $stable(dac3_code_o));

  AST_FLAG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) // R5
    lat_pulse |=> (flag_o == $past(frame[FLAG_BIT])) && (flag_oe_o == $past(frame[OE_BIT])));

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) // R5
    !lat_pulse |=> $stable(flag_o) && $stable(flag_oe_o));
endmodule

bind aux_dac_port aux_dac_port_chk #(
  .DAC1_W(DAC1_W),
  .DAC2_W(DAC2_W),
  .DAC3_W(DAC3_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shift_en   (shift_en),
  .lat_pulse  (lat_pulse),
  .lat_s      (lat_s),
  .dat_s      (dat_s),
  .frame      (frame),
  .dac1_code_o(dac1_code_o),
  .dac2_code_o(dac2_code_o),
  .dac3_code_o(dac3_code_o),
  .flag_o     (flag_o),
  .flag_oe_o  (flag_oe_o)
);

// File: tb/aux_dac_port_tb.sv
module aux_dac_port_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_clk_i = 1'b1;
  logic       ser_dat_i = 1'b0;
  logic       ser_lat_i = 1'b1;
  logic [8:0] dac1;
  logic [9:0] dac2;
  logic [7:0] dac3;
  logic [2:0] lowpwr;
  logic       flag, flag_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  aux_dac_port u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ser_clk_i   (ser_clk_i),
    .ser_dat_i   (ser_dat_i),
    .ser_lat_i   (ser_lat_i),
    .dac1_code_o (dac1),
    .dac2_code_o (dac2),
    .dac3_code_o (dac3),
    .dac_lowpwr_o(lowpwr),
    .flag_o      (flag),
    .flag_oe_o   (flag_oe)
  );

  // reference model: input history queue, {clk, lat, dat} per sample
  logic [2:0]  hist [$];
  logic [15:0] m_frame;
  logic [8:0]  m_d1;
  logic [9:0]  m_d2;
  logic [7:0]  m_d3;
  logic        m_flag, m_oe;

  function automatic logic [2:0] m_lp();
    return {(m_d3 == 8'h00) || (m_d3 == 8'hFF),
            (m_d2 == 10'h000) || (m_d2 == 10'h3FF),
            (m_d1 == 9'h000) || (m_d1 == 9'h1FF)};
  endfunction

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < 4; i++) hist.push_front(3'b110);
    m_frame = '0; m_d1 = '0; m_d2 = '0; m_d3 = '0; m_flag = 1'b0; m_oe = 1'b0;
  endtask

  initial model_reset();

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      model_reset();
    end else begin
      logic [2:0] now, old;
      hist.push_front({ser_clk_i, ser_lat_i, ser_dat_i});
      void'(hist.pop_back());
      now = hist[2];
      old = hist[3];
      if (now[1] && !old[1]) begin
        if (m_frame[11]) m_d1 = m_frame[8:0];
        if (m_frame[12]) m_d2 = m_frame[9:0];
        if (m_frame[10]) m_d3 = m_frame[7:0];
        m_flag = m_frame[15];
        m_oe   = m_frame[14];
      end else if (old[2] && !now[2] && !now[1]) begin
        m_frame = {m_frame[14:0], now[0]};
      end
    end
  end

  // R10: cycle-exact comparison with the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if ({dac1, dac2, dac3, lowpwr, flag, flag_oe} !== {m_d1, m_d2, m_d3, m_lp(), m_flag, m_oe}) begin
        errors++;
        $display("FAIL R10 t=%0t actual %h/%h/%h/%b/%b/%b expected %h/%h/%h/%b/%b/%b", $time,
                 dac1, dac2, dac3, lowpwr, flag, flag_oe, m_d1, m_d2, m_d3, m_lp(), m_flag, m_oe);
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    ser_lat_i = 1'b0;
    wait_n(4);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat_i = bits[i];
      ser_clk_i = 1'b1;
      wait_n(4);
      ser_clk_i = 1'b0;
      wait_n(4);
      ser_clk_i = 1'b1;
    end
    wait_n(4);
  endtask

  task automatic commit();
    ser_lat_i = 1'b1;
    wait_n(8);
  endtask

  task automatic pulses_latch_high(input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat_i = 1'b1;
      ser_clk_i = 1'b0;
      wait_n(4);
      ser_clk_i = 1'b1;
      wait_n(4);
    end
  endtask

  task automatic expect_all(input string req, input int e1, input int e2, input int e3,
                            input int elp, input int ef, input int eoe);
    chk({req, " dac1"}, dac1, e1);
    chk({req, " dac2"}, dac2, e2);
    chk({req, " dac3"}, dac3, e3);
    chk("R7 lowpwr", lowpwr, elp);
    chk({"R5 flag ", req}, flag, ef);
    chk({"R5 oe ", req}, flag_oe, eoe);
  endtask

  initial begin
    wait_n(3);
    // R9 reset state
    expect_all("R9", 0, 0, 0, 3'b111, 0, 0);
    rst_ni = 1'b1;
    wait_n(4);

    // R1 R3 R4: select converter 1 only; R10 latency of commit
    shift_bits(32'h0000_C8A5, 16);
    ser_lat_i = 1'b1;
    wait_n(2);
    chk("R10 before third edge", dac1, 0);
    wait_n(1);
    chk("R10 on third edge", dac1, 9'h0A5);
    wait_n(4);
    expect_all("R3 R4 single", 9'h0A5, 0, 0, 3'b110, 1, 1);

    // R3 multi-select, R6 bit 13 set, R7 all ones
    shift_bits(32'h0000_7FFF, 16);
    commit();
    expect_all("R3 R6 multi", 9'h1FF, 10'h3FF, 8'hFF, 3'b111, 0, 1);

    // R4 only converter 3 changes
    shift_bits(32'h0000_864B, 16);
    commit();
    expect_all("R4 sel3", 9'h1FF, 10'h3FF, 8'h4B, 3'b011, 1, 0);

    // R2 clocks with latch high ignored, then R8 short frame of 8 bits
    pulses_latch_high(16);
    shift_bits(32'h0000_005A, 8);
    commit();
    expect_all("R2 R8 short", 9'h15A, 10'h3FF, 8'h4B, 3'b010, 0, 1);

    // R8 long frame of 20 bits, last 16 used
    shift_bits(32'h000F_0800, 20);
    commit();
    expect_all("R8 long", 0, 10'h3FF, 8'h4B, 3'b011, 0, 0);

    // R6 only bit 13 among control bits: no converter changes
    shift_bits(32'h0000_6155, 16);
    commit();
    expect_all("R6 spare", 0, 10'h3FF, 8'h4B, 3'b011, 0, 1);

    // R9 reset again
    rst_ni = 1'b0;
    wait_n(2);
    expect_all("R9 again", 0, 0, 0, 3'b111, 0, 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule